// File: doc/BRIEF.md
# Weighted Signature Similarity Comparator

This unit takes two event-history signatures of equal length and reports how closely they agree. Each signature is a packed string of small event codes, one per history slot. Slots are compared position by position. A matching slot adds its one-based position index to an integer score, so slots nearer the newest end count for more. The score reaches its maximum, the triangular number k(k+1)/2, only when every slot agrees. It is zero when no slot agrees.

A pair is judged foldable into one representative when the normalised score is at least nine tenths. The hardware evaluates this without division, as 20·S ≥ 9·k·(k+1). Signatures are only meaningful to compare when they belong to the same anchor program counter. When the caller presents both anchors and they differ, the verdict flags are forced low.

A one-cycle start strobe launches a compare. The results appear on registered outputs in the next cycle, qualified by a one-cycle valid pulse, and they hold until the next compare.

Top module: `wsig_compare`

## Requirements
- R1: One clock edge after `start` is sampled high, `res_valid` is high for exactly one cycle. Without a start on the previous edge, `res_valid` is low.
- R2: Entry i (1 = oldest, k = newest) occupies bits [(i-1)·W +: W] of each history. `res_score` equals the sum of i over all positions whose two codes are equal.
- R3: `res_same` is high exactly when `res_score` equals k(k+1)/2 and the anchor check passes.
- R4: `res_close` is high exactly when 20·`res_score` ≥ 9·k·(k+1) and the anchor check passes. For k = 32 this means a score of 476 or more.
- R5: When `anchor_en` is high and `anchor_a` differs from `anchor_b`, `res_same` and `res_close` are low, while `res_score` still carries the weighted sum.
- R6: When `anchor_en` is low, the anchor values have no effect on any output.
- R7: While `rst` is high, and in the first cycle after it falls, `res_valid`, `res_score`, `res_same` and `res_close` are all zero.
- R8: Between valid pulses, `res_score`, `res_same` and `res_close` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a compare of the present inputs |
| hist_a | input | DEPTH*CODE_W | First signature, oldest entry in the low bits |
| hist_b | input | DEPTH*CODE_W | Second signature, same layout |
| anchor_en | input | 1 | Anchors are presented and must agree |
| anchor_a | input | PC_W | Anchor PC of the first signature |
| anchor_b | input | PC_W | Anchor PC of the second signature |
| res_valid | output | 1 | One-cycle result strobe |
| res_score | output | SUM_W | Integer weighted match sum |
| res_same | output | 1 | Signatures fully identical |
| res_close | output | 1 | Signatures similar (score ≥ 0.9) |

## Verification
The bench drives pairs that differ only in the oldest slot or only in the newest slot, giving scores of 527 and 496. A design that reversed the position order, or that weighted all slots equally, would report other values. It also sits on the threshold with scores of 476 and 475. A divider-style rounding or an off-by-one in the constant would flip the similar verdict there. Anchor mismatches are driven both with the check enabled and with it disabled. A design that ignored the enable, or that also cleared the score, would be caught. Back-to-back starts and idle gaps expose a valid strobe that stretches, or results that drift between pulses.

// File: rtl/wsig_pkg.sv
package wsig_pkg;

  // Triangular number: the largest possible weighted sum for a history of n slots.
  function automatic int tri_total(input int n);
    return (n * (n + 1)) / 2;
  endfunction

  // 90 percent threshold rendered as 20*S >= 9*n*(n+1), with no division.
  function automatic int close_bound(input int n);
    return 9 * n * (n + 1);
  endfunction

endpackage

// File: rtl/wsig_slot_match.sv
module wsig_slot_match #(
  parameter int DEPTH  = 32,
  parameter int CODE_W = 3
) (
  input  logic [DEPTH*CODE_W-1:0] hist_a,
  input  logic [DEPTH*CODE_W-1:0] hist_b,
  output logic [DEPTH-1:0]        slot_eq
);

  // One comparator per history slot; bit j corresponds to position j+1.
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    assign slot_eq[j] = (hist_a[j*CODE_W +: CODE_W] == hist_b[j*CODE_W +: CODE_W]);
  end

endmodule

// File: rtl/wsig_weight_sum.sv
module wsig_weight_sum #(
  parameter int DEPTH = 32,
  parameter int SUM_W = 10
) (
  input  logic [DEPTH-1:0] slot_eq,
  output logic [SUM_W-1:0] wsum
);

  // Each matching slot adds its one-based position.
  always_comb begin
    wsum = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (slot_eq[j]) wsum = wsum + SUM_W'(j + 1);
    end
  end

endmodule

// File: rtl/wsig_verdict.sv
module wsig_verdict
  import wsig_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SUM_W-1:0] wsum,
  input  logic             anchor_ok,
  output logic             res_valid,
  output logic [SUM_W-1:0] res_score,
  output logic             res_same,
  output logic             res_close
);

  localparam int CMP_W = SUM_W + 5;
  localparam logic [SUM_W-1:0] FULL  = SUM_W'(tri_total(DEPTH));
  localparam logic [CMP_W-1:0] BOUND = CMP_W'(close_bound(DEPTH));

  logic [CMP_W-1:0] scaled;
  logic             same_c;
  logic             close_c;

  assign scaled  = CMP_W'(wsum) * CMP_W'(20);
  assign same_c  = anchor_ok && (wsum == FULL);
  assign close_c = anchor_ok && (scaled >= BOUND);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_score <= '0;
      res_same  <= 1'b0;
      res_close <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_score <= wsum;
        res_same  <= same_c;
        res_close <= close_c;
      end
    end
  end

  a_r1_valid_follows_start: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);

  a_r1_valid_needs_start: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);

  a_r2_score_in_range: assert property (@(posedge clk) disable iff (rst)
    res_score <= FULL);

  a_r3_same_implies_close: assert property (@(posedge clk) disable iff (rst)
    res_same |-> res_close);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(res_score) && $stable(res_same) && $stable(res_close)));

endmodule

// File: rtl/wsig_compare.sv
module wsig_compare
  import wsig_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CODE_W = 3,
  parameter int PC_W   = 32,
  parameter int SUM_W  = $clog2(tri_total(DEPTH) + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [DEPTH*CODE_W-1:0] hist_a,
  input  logic [DEPTH*CODE_W-1:0] hist_b,
  input  logic                    anchor_en,
  input  logic [PC_W-1:0]         anchor_a,
  input  logic [PC_W-1:0]         anchor_b,
  output logic                    res_valid,
  output logic [SUM_W-1:0]        res_score,
  output logic                    res_same,
  output logic                    res_close
);

  logic [DEPTH-1:0] slot_eq;
  logic [SUM_W-1:0] wsum;
  logic             anchor_ok;

  assign anchor_ok = !anchor_en || (anchor_a == anchor_b);

  wsig_slot_match #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_match (
    .hist_a  (hist_a),
    .hist_b  (hist_b),
    .slot_eq (slot_eq)
  );

  wsig_weight_sum #(.DEPTH(DEPTH), .SUM_W(SUM_W)) u_sum (
    .slot_eq (slot_eq),
    .wsum    (wsum)
  );

  wsig_verdict #(.DEPTH(DEPTH), .SUM_W(SUM_W)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wsum      (wsum),
    .anchor_ok (anchor_ok),
    .res_valid (res_valid),
    .res_score (res_score),
    .res_same  (res_same),
    .res_close (res_close)
  );

  a_r5_anchor_clash_blocks: assert property (@(posedge clk) disable iff (rst)
    (start && anchor_en && (anchor_a != anchor_b)) |=> (!res_same && !res_close));

  a_r3_same_means_all_equal: assert property (@(posedge clk) disable iff (rst)
    (start && (hist_a != hist_b)) |=> !res_same);

endmodule

// File: tb/sim_wsig_compare.sv
module sim_wsig_compare;

  localparam int K  = 32;
  localparam int W  = 3;
  localparam int PW = 32;
  localparam int SW = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [K*W-1:0] hist_a = '0;
  logic [K*W-1:0] hist_b = '0;
  logic           anchor_en = 1'b0;
  logic [PW-1:0]  anchor_a = '0;
  logic [PW-1:0]  anchor_b = '0;
  logic           res_valid;
  logic [SW-1:0]  res_score;
  logic           res_same;
  logic           res_close;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int    score;
    bit    same;
    bit    close;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  wsig_compare #(.DEPTH(K), .CODE_W(W), .PC_W(PW)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .hist_a(hist_a), .hist_b(hist_b),
    .anchor_en(anchor_en), .anchor_a(anchor_a), .anchor_b(anchor_b),
    .res_valid(res_valid), .res_score(res_score),
    .res_same(res_same), .res_close(res_close)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected values come straight from the requirement text.
  task automatic launch(input logic [K*W-1:0] a, input logic [K*W-1:0] b,
                        input bit en, input logic [PW-1:0] pa,
                        input logic [PW-1:0] pb, input string tag);
    exp_t e;
    int s;
    bit ok;
    s = 0;
    for (int i = 1; i <= K; i++) begin
      if (a[(i-1)*W +: W] == b[(i-1)*W +: W]) s += i;
    end
    ok = !en || (pa == pb);
    e.score = s;
    e.same  = ok && (s == K*(K+1)/2);
    e.close = ok && (20*s >= 9*K*(K+1));
    e.tag   = tag;
    sb.push_back(e);
    hist_a = a; hist_b = b; anchor_en = en; anchor_a = pa; anchor_b = pb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each strobe.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        check(0, "R1 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_score == SW'(e.score), {e.tag, " R2 score"}, int'(res_score), e.score);
        check(res_same == e.same, {e.tag, " R3 same"}, int'(res_same), int'(e.same));
        check(res_close == e.close, {e.tag, " R4 close"}, int'(res_close), int'(e.close));
      end
    end
  end

  function automatic logic [K*W-1:0] flip(input logic [K*W-1:0] v, input int pos);
    logic [K*W-1:0] r;
    r = v;
    r[(pos-1)*W] = ~r[(pos-1)*W];
    return r;
  endfunction

  initial begin
    logic [K*W-1:0] base;
    logic [31:0] lf;
    for (int i = 0; i < K; i++) base[i*W +: W] = W'(i * 5 + 1);

    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_score == 0 && !res_same && !res_close,
          "R7 during reset", int'(res_score), 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 0 && res_score == 0 && !res_same && !res_close,
          "R7 after reset", int'(res_valid), 0);

    launch(base, base, 0, 0, 0, "R3 identical");
    @(negedge clk);
    launch(base, ~base, 0, 0, 0, "R2 none equal");
    @(negedge clk);
    launch(base, flip(base, 1), 0, 0, 0, "R2 oldest differs");
    @(negedge clk);
    launch(base, flip(base, K), 0, 0, 0, "R2 newest differs");
    @(negedge clk);
    launch(base, flip(flip(base, 32), 20), 0, 0, 0, "R4 score 476");
    @(negedge clk);
    launch(base, flip(flip(base, 32), 21), 0, 0, 0, "R4 score 475");
    @(negedge clk);
    launch(base, base, 1, 32'h1000, 32'h1004, "R5 anchor clash");
    @(negedge clk);
    launch(base, flip(base, 3), 1, 32'h2000, 32'h2004, "R5 clash close pair");
    @(negedge clk);
    launch(base, base, 1, 32'h3000, 32'h3000, "R5 anchors agree");
    @(negedge clk);
    launch(base, base, 0, 32'h1000, 32'h1004, "R6 anchors ignored");
    @(negedge clk);

    // R8: hold between strobes.
    launch(base, flip(base, 5), 0, 0, 0, "R8 before hold");
    hist_b = ~base;
    repeat (4) begin
      @(negedge clk);
      check(!res_valid && res_score == SW'(528 - 5) && res_close,
            "R8 hold", int'(res_score), 523);
    end

    // R1: back-to-back launches.
    launch(base, base, 0, 0, 0, "R1 b2b first");
    launch(base, flip(base, 2), 0, 0, 0, "R1 b2b second");
    launch(base, flip(base, 9), 0, 0, 0, "R1 b2b third");
    @(negedge clk);
    @(negedge clk);
    check(!res_valid, "R1 strobe ends", int'(res_valid), 0);

    lf = 32'hACE1_2345;
    for (int n = 0; n < 40; n++) begin
      logic [K*W-1:0] b;
      b = base;
      for (int i = 0; i < K; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[2:0] == 3'd0 || (n < 10 && lf[4])) b[i*W +: W] = lf[7:5];
      end
      launch(base, b, lf[9], 32'h40, {31'h20, lf[10]}, "R2 mixed");
      if (lf[11]) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 all results seen", sb.size(), 0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule